// File: doc/BRIEF.md
# Condition-Field Predicate-Result Write Filter

This block sits between the unit that computes a vectorised condition-field operation and the condition-register file. For each element it receives the predicate bit, the mode controls of the instruction and the computed result. It decides whether anything is written back and, if so, which value. The result is either a whole 4-bit field or a single bit. It takes one element per cycle over a valid/ready handshake and presents a registered write request one cycle later.

The filtering mode tests the operation's own result, not a side result. An active element is written only when its tested bit equals the invert control. A masked-out element is either skipped or overwritten with the fill value, depending on the zeroing control. The fill is one bit in single-bit form, or the fill bit replicated across the whole field in field form. A reserved mode encoding produces an illegal-mode pulse and no write.

Top module: `crpr_filter`

## Requirements
- R1: While `rst` is high, `wr_en`, `illegal` and `in_ready` are 0. `in_ready` becomes 1 at the first clock edge after `rst` falls.
- R2: An element is accepted on a rising edge where `in_valid` and `in_ready` are both 1. Its outputs appear after that same edge. After an edge with no accepted element, `wr_en` and `illegal` are 0.
- R3: When `mode` is 2'b10 (reserved), an accepted element gives `illegal`=1 and `wr_en`=0.
- R4: When `mode` is 2'b11 (filter mode), `pred`=0 and `zero_fill`=0, the element gives `wr_en`=0.
- R5: When `mode` is 2'b11, `pred`=0, `zero_fill`=1 and `bit_form`=0 (field form), the element gives `wr_en`=1, `wr_single`=0 and `wr_data` equal to four copies of `fill_val`. The `inv` input has no effect.
- R6: When `mode` is 2'b11, `pred`=0, `zero_fill`=1 and `bit_form`=1 (single-bit form), the element gives `wr_en`=1, `wr_single`=1, `wr_data[0]`=`fill_val` and `wr_data[3:1]`=0. The `inv` input has no effect.
- R7: When `mode` is 2'b11, `pred`=1 and `bit_form`=1, `res_bit` is the tested bit. The write happens only if `res_bit` equals `inv`, with `wr_single`=1 and `wr_data`={3'b000, `res_bit`}.
- R8: When `mode` is 2'b11, `pred`=1 and `bit_form`=0, the tested bit is `res_field[bit_sel]`, where `bit_sel`=0 selects the least significant bit. The write happens only if that bit equals `inv`, with `wr_single`=0 and `wr_data`=`res_field`.
- R9: When `mode` is 2'b00 or 2'b01, an element with `pred`=1 is written unconditionally with its result, using the same data and `wr_single` as in R7 and R8. An element with `pred`=0 is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Mode select: 11 filter, 10 reserved, 00/01 unfiltered |
| zero_fill | input | 1 | 1: masked-out elements are overwritten with the fill value |
| fill_val | input | 1 | Value written into masked-out elements |
| inv | input | 1 | Value the tested bit must equal for the write to proceed |
| bit_sel | input | 2 | Index of the tested bit in field form |
| bit_form | input | 1 | 1: single-bit result, 0: 4-bit field result |
| in_valid | input | 1 | Element present |
| in_ready | output | 1 | Block can accept an element |
| pred | input | 1 | Predicate bit of the element |
| res_field | input | 4 | Field result (field form) |
| res_bit | input | 1 | Bit result (single-bit form) |
| wr_en | output | 1 | Write request to the condition register |
| wr_data | output | 4 | Write value |
| wr_single | output | 1 | 1: only bit 0 of `wr_data` is to be written |
| illegal | output | 1 | Reserved mode seen on the accepted element |

## Verification
The assertions assume that the mode controls, predicate and result inputs are known whenever `in_valid` is high. They also assume that these inputs are meaningful only on the edge that accepts the element. The bench drives all inputs at the falling edge and holds them through the next rising edge. It waits for `in_ready` before it offers elements, and it inserts idle cycles so that the assertion for the no-accept case is exercised as well.

// File: rtl/crpr_pkg.sv
package crpr_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN  = 2'b00,
    MODE_FFIRST = 2'b01,
    MODE_RSVD   = 2'b10,
    MODE_FILTER = 2'b11
  } crpr_mode_e;

  typedef struct packed {
    logic is_filter;
    logic is_rsvd;
  } crpr_dec_t;
endpackage

// File: rtl/crpr_decode.sv
module crpr_decode
  import crpr_pkg::*;
(
  input  logic [1:0] mode,
  output crpr_dec_t  dec
);
  always_comb begin
    dec.is_filter = (crpr_mode_e'(mode) == MODE_FILTER);
    dec.is_rsvd   = (crpr_mode_e'(mode) == MODE_RSVD);
  end
endmodule

// File: rtl/crpr_eval.sv
module crpr_eval
  import crpr_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int SEL_W = $clog2(FIELD_W)
) (
  input  crpr_dec_t          dec,
  input  logic               pred,
  input  logic               zero_fill,
  input  logic               fill_val,
  input  logic               inv,
  input  logic [SEL_W-1:0]   bit_sel,
  input  logic               bit_form,
  input  logic [FIELD_W-1:0] res_field,
  input  logic               res_bit,
  output logic               en_d,
  output logic [FIELD_W-1:0] data_d,
  output logic               single_d,
  output logic               illegal_d
);
  logic [FIELD_W-1:0] fill_vec;
  logic               tested;

  // replicated fill for field form
  for (genvar g = 0; g < FIELD_W; g++) begin : g_fill
    assign fill_vec[g] = fill_val;
  end

  always_comb begin
    tested    = bit_form ? res_bit : res_field[bit_sel];
    en_d      = 1'b0;
    data_d    = '0;
    single_d  = bit_form;
    illegal_d = dec.is_rsvd;
    if (!dec.is_rsvd) begin
      if (!pred) begin
        if (dec.is_filter && zero_fill) begin
          en_d   = 1'b1;
          data_d = bit_form ? {{(FIELD_W-1){1'b0}}, fill_val} : fill_vec;
        end
      end else begin
        en_d   = dec.is_filter ? (tested == inv) : 1'b1;
        data_d = bit_form ? {{(FIELD_W-1){1'b0}}, res_bit} : res_field;
      end
    end
  end
endmodule

// File: rtl/crpr_filter.sv
module crpr_filter
  import crpr_pkg::*;
#(
  parameter int FIELD_W = 4,
  localparam int SEL_W = $clog2(FIELD_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               zero_fill,
  input  logic               fill_val,
  input  logic               inv,
  input  logic [SEL_W-1:0]   bit_sel,
  input  logic               bit_form,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               pred,
  input  logic [FIELD_W-1:0] res_field,
  input  logic               res_bit,
  output logic               wr_en,
  output logic [FIELD_W-1:0] wr_data,
  output logic               wr_single,
  output logic               illegal
);
  crpr_dec_t          dec;
  logic               en_d, single_d, illegal_d;
  logic [FIELD_W-1:0] data_d;
  logic               take;

  assign take = in_valid && in_ready;

  crpr_decode u_dec (.mode(mode), .dec(dec));

  crpr_eval #(.FIELD_W(FIELD_W)) u_eval (
    .dec(dec), .pred(pred), .zero_fill(zero_fill), .fill_val(fill_val),
    .inv(inv), .bit_sel(bit_sel), .bit_form(bit_form),
    .res_field(res_field), .res_bit(res_bit),
    .en_d(en_d), .data_d(data_d), .single_d(single_d), .illegal_d(illegal_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready  <= 1'b0;
      wr_en     <= 1'b0;
      wr_data   <= '0;
      wr_single <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      wr_en    <= take && en_d;
      illegal  <= take && illegal_d;
      if (take) begin
        wr_data   <= data_d;
        wr_single <= single_d;
      end
    end
  end
endmodule

// File: rtl/crpr_filter_chk.sv
module crpr_filter_chk #(
  parameter int FIELD_W = 4,
  localparam int SEL_W = $clog2(FIELD_W)
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         mode,
  input logic               zero_fill,
  input logic               fill_val,
  input logic               inv,
  input logic [SEL_W-1:0]   bit_sel,
  input logic               bit_form,
  input logic               in_valid,
  input logic               in_ready,
  input logic               pred,
  input logic [FIELD_W-1:0] res_field,
  input logic               res_bit,
  input logic               wr_en,
  input logic [FIELD_W-1:0] wr_data,
  input logic               wr_single,
  input logic               illegal
);
  logic take;
  assign take = in_valid && in_ready;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !take |=> (!wr_en && !illegal));

  assert_rsvd_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b10) |=> (illegal && !wr_en));

  assert_skip_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b11 && !pred && !zero_fill) |=> !wr_en);

  assert_fill_field_R5: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b11 && !pred && zero_fill && !bit_form)
      |=> (wr_en && !wr_single && wr_data == {FIELD_W{$past(fill_val)}}));

  assert_single_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_single) |-> (wr_data[FIELD_W-1:1] == '0));

  assert_bit_test_R7: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 2'b11 && pred && bit_form)
      |=> (wr_en == ($past(res_bit) == $past(inv))));
endmodule

bind crpr_filter crpr_filter_chk #(.FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/crpr_filter_test.sv
module crpr_filter_test;
  localparam int PERIOD = 10;

  typedef struct {
    logic       en;
    logic [3:0] data;
    logic       single;
    logic       ill;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       zero_fill = 1'b0, fill_val = 1'b0, inv = 1'b0;
  logic [1:0] bit_sel = 2'b00;
  logic       bit_form = 1'b0, in_valid = 1'b0, pred = 1'b0, res_bit = 1'b0;
  logic [3:0] res_field = 4'h0;
  logic       in_ready, wr_en, wr_single, illegal;
  logic [3:0] wr_data;

  int checks = 0;
  int errors = 0;
  exp_t sb[$];
  bit done = 1'b0;

  crpr_filter uut (
    .clk(clk), .rst(rst), .mode(mode), .zero_fill(zero_fill), .fill_val(fill_val),
    .inv(inv), .bit_sel(bit_sel), .bit_form(bit_form), .in_valid(in_valid),
    .in_ready(in_ready), .pred(pred), .res_field(res_field), .res_bit(res_bit),
    .wr_en(wr_en), .wr_data(wr_data), .wr_single(wr_single), .illegal(illegal)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: one element per call, expected value pushed to scoreboard
  task automatic send(input logic [1:0] m, input logic p, input logic zf,
                      input logic fv, input logic iv, input logic [1:0] sel,
                      input logic bf, input logic [3:0] fld, input logic b,
                      input string tag);
    exp_t e;
    logic tb;
    @(negedge clk);
    mode = m; pred = p; zero_fill = zf; fill_val = fv; inv = iv;
    bit_sel = sel; bit_form = bf; res_field = fld; res_bit = b; in_valid = 1'b1;
    e.tag = tag; e.en = 1'b0; e.data = 4'h0; e.single = bf; e.ill = 1'b0;
    if (m == 2'b10) e.ill = 1'b1;
    else if (!p) begin
      if (m == 2'b11 && zf) begin
        e.en = 1'b1;
        e.data = bf ? {3'b000, fv} : {fv, fv, fv, fv};
      end
    end else begin
      tb = bf ? b : fld[sel];
      e.data = bf ? {3'b000, b} : fld;
      e.en = (m != 2'b11) || (tb == iv);
    end
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0;
    e.tag = tag; e.en = 1'b0; e.data = 4'h0; e.single = 1'b0; e.ill = 1'b0;
    sb.push_back(e);
  endtask

  // monitor: compares registered outputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (wr_en !== e.en || illegal !== e.ill ||
            (e.en && (wr_data !== e.data || wr_single !== e.single))) begin
          errors++;
          $display("FAIL %s: got en=%b data=%h single=%b ill=%b, expected en=%b data=%h single=%b ill=%b",
                   e.tag, wr_en, wr_data, wr_single, illegal, e.en, e.data, e.single, e.ill);
        end
      end
    end
  end

  initial begin
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(wr_en === 1'b0 && illegal === 1'b0 && in_ready === 1'b0,
        $sformatf("R1 reset: en=%b ill=%b rdy=%b expected 0 0 0", wr_en, illegal, in_ready));
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready === 1'b1, $sformatf("R1 ready after reset: got %b expected 1", in_ready));

    // R7: single-bit form, tested bit equals / differs from inv
    send(2'b11, 1, 0, 0, 1, 2'd0, 1, 4'h0, 1, "R7 bit=1 inv=1 write");
    send(2'b11, 1, 0, 0, 0, 2'd0, 1, 4'h0, 1, "R7 bit=1 inv=0 cancel");
    send(2'b11, 1, 0, 0, 0, 2'd0, 1, 4'hF, 0, "R7 bit=0 inv=0 write");
    idle("R2 idle cycle");
    // R8: field form, every selector position
    for (int s = 0; s < 4; s++) begin
      send(2'b11, 1, 0, 0, 1, s[1:0], 0, 4'b0101, 0, "R8 sel sweep inv=1");
      send(2'b11, 1, 0, 0, 0, s[1:0], 0, 4'b0101, 0, "R8 sel sweep inv=0");
    end
    // R4: masked, no zero fill
    send(2'b11, 0, 0, 1, 0, 2'd0, 0, 4'hA, 1, "R4 masked skip field");
    send(2'b11, 0, 0, 1, 1, 2'd0, 1, 4'hA, 1, "R4 masked skip bit");
    // R5: masked with fill, field form, inv ignored
    send(2'b11, 0, 1, 1, 0, 2'd2, 0, 4'h0, 0, "R5 fill ones inv=0");
    send(2'b11, 0, 1, 0, 1, 2'd2, 0, 4'hF, 1, "R5 fill zeros inv=1");
    // R6: masked with fill, single-bit form, inv ignored
    send(2'b11, 0, 1, 1, 0, 2'd0, 1, 4'hF, 0, "R6 fill bit one");
    send(2'b11, 0, 1, 0, 1, 2'd0, 1, 4'hF, 1, "R6 fill bit zero");
    // R3: reserved
    send(2'b10, 1, 1, 1, 1, 2'd1, 0, 4'hC, 1, "R3 reserved active");
    send(2'b10, 0, 1, 1, 0, 2'd1, 1, 4'hC, 1, "R3 reserved masked");
    idle("R2 idle after reserved");
    // R9: unfiltered modes
    send(2'b00, 1, 0, 0, 1, 2'd0, 0, 4'h6, 0, "R9 plain field");
    send(2'b01, 1, 0, 0, 1, 2'd3, 1, 4'h6, 0, "R9 ffirst bit");
    send(2'b00, 0, 1, 1, 0, 2'd0, 0, 4'h6, 0, "R9 plain masked");
    send(2'b01, 0, 1, 1, 0, 2'd0, 1, 4'h6, 0, "R9 ffirst masked");
    // R2: back-to-back after idle gaps
    idle("R2 idle");
    idle("R2 idle 2");
    send(2'b11, 1, 0, 0, 1, 2'd3, 0, 4'h8, 0, "R2 resume field");
    idle("R2 drain");
    @(negedge clk);
    @(negedge clk);
    chk(sb.size() == 0, $sformatf("R2 scoreboard drained: got %0d expected 0", sb.size()));
    done = 1'b1;
    report();
  end
endmodule